// File: doc/BRIEF.md
# External DMA Request/Acknowledge Controller

This block sits between an off-chip DMA request pin and the initiator input of an internal DMA engine. It turns activity on the pin into a request toward the engine. It watches a simplified internal bus-transfer strobe, and when a transfer of the selected kind completes it answers the off-chip device with an acknowledge pulse.

An 8-bit control register sets the behaviour. It holds an enable bit, a request mode, a bus-type selector, an acknowledge width and an input-timing bit. Four request styles are available. Level mode forwards the pin's sampled level. Edge mode latches one request per rising edge. Piped mode counts sampled request cycles into a small outstanding-request store and retires one per matching transfer. Idle mode forwards nothing.

Top module: `xdr_dreq_ctrl`

## Requirements
- R1: The control register resets to zero. Writes store data bits 7:0 and the register reads back in the same layout. The layout is mode in [7:6], bus select in [5:4], acknowledge width in [3:2], timing bit in [1] and enable in [0]. Bits 31:8 always read zero and writes to them are discarded.
- R2: While the enable bit is 0, `init_req` and `ack_pin` stay low whatever the pin and bus do.
- R3: The mode values are 00 idle, 01 level, 10 edge and 11 piped. With mode 00 and the block enabled, `init_req` stays low and no transfer starts an acknowledge.
- R4: Timing bit 1 samples the pin through one flop, so in level mode `init_req` rises one clock after the pin. Timing bit 0 adds a second synchronizer flop, which makes the delay two clocks. Piped mode always uses the one-flop path, whatever the timing bit holds.
- R5: In level mode `init_req` equals the sampled pin level.
- R6: A transfer matches only when `bus_valid` is high and {`bus_is_periph`,`bus_is_read`} equals the bus-select field. The codes are 00 memory write, 01 memory read, 10 peripheral write and 11 peripheral read.
- R7: In level mode every matching transfer drives `ack_pin` high for width+1 clocks, so width codes 0 to 3 give 1 to 4 clocks. The pulse starts on the clock after the transfer. In edge mode a matching transfer that meets a pending request does the same.
- R8: In edge mode a rising edge of the sampled pin sets a pending request, and `init_req` shows that request. A matching transfer clears it and acknowledges it. Rising edges that arrive while a request is pending are not queued.
- R9: In piped mode each clock with the sampled pin high adds one outstanding request, up to 4. `init_req` is high while the count is non-zero. Each matching transfer with a non-zero count retires one request and gives a one-clock acknowledge. The width field is ignored in this mode.
- R10: A matching transfer that arrives while an acknowledge pulse is running restarts the pulse at its full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read data |
| req_pin | input | 1 | Off-chip DMA request pin |
| bus_valid | input | 1 | Internal bus transfer strobe |
| bus_is_periph | input | 1 | Transfer targets a peripheral (1) or memory (0) |
| bus_is_read | input | 1 | Transfer is a read (1) or a write (0) |
| init_req | output | 1 | Initiator request toward the DMA engine |
| ack_pin | output | 1 | Acknowledge pulse to the off-chip device |

## Verification
Two situations are hardest to reach from the ports. The first is a saturated piped store, where extra pin cycles must be dropped. The second is a transfer that lands in the middle of a running acknowledge. The stimulus holds the pin high for six cycles, which overfills the four-entry store. It then issues five spaced transfers and counts four one-clock acknowledges. For the restart case, a second matching transfer is placed on the second clock of a four-clock pulse. The pulse must then still be high three clocks later. Edge mode gets a second rising edge while a request is pending, and the bench confirms that no extra request survives the acknowledge.

// File: rtl/xdr_pkg.sv
package xdr_pkg;
  localparam int CFG_W = 8;
  localparam int WID_W = 2;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_LEVEL = 2'b01,
    MODE_EDGE  = 2'b10,
    MODE_PIPED = 2'b11
  } xdr_mode_e;

  typedef struct packed {
    xdr_mode_e        mode;
    logic [1:0]       bsel;
    logic [WID_W-1:0] wid;
    logic             sync;
    logic             en;
  } xdr_cfg_t;
endpackage

// File: rtl/xdr_cfg_reg.sv
module xdr_cfg_reg
  import xdr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output xdr_cfg_t          cfg,
  output logic [DATA_W-1:0] rdata
);
  xdr_cfg_t cfg_q, cfg_d;
  logic     unused_wdata_hi;

  always_comb begin
    cfg_d = xdr_cfg_t'(wdata[CFG_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (we) cfg_q <= cfg_d;
  end

  assign unused_wdata_hi = ^wdata[DATA_W-1:CFG_W];
  assign cfg   = cfg_q;
  assign rdata = {{(DATA_W-CFG_W){1'b0}}, cfg_q};
endmodule

// File: rtl/xdr_req_front.sv
module xdr_req_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic direct,
  output logic smp,
  output logic rise
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= smp;
    end
  end

  assign smp  = direct ? chain_q[0] : chain_q[STAGES-1];
  assign rise = smp & ~prev_q;
endmodule

// File: rtl/xdr_req_track.sv
module xdr_req_track
  import xdr_pkg::*;
#(
  parameter int PIPE_DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  xdr_cfg_t  cfg,
  input  logic      smp,
  input  logic      rise,
  input  logic      hit,
  output logic      init_req,
  output logic      trig
);
  localparam int CNT_W = $clog2(PIPE_DEPTH + 1);

  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             retire, inc;

  always_comb begin
    retire = hit && (cnt_q != '0);
    inc    = smp && ((cnt_q != CNT_W'(PIPE_DEPTH)) || retire);

    pend_d = 1'b0;
    if (cfg.en && cfg.mode == MODE_EDGE) pend_d = pend_q ? !hit : rise;

    cnt_d = '0;
    if (cfg.en && cfg.mode == MODE_PIPED)
      cnt_d = cnt_q - CNT_W'(retire) + CNT_W'(inc);

    trig = 1'b0;
    init_req = 1'b0;
    if (cfg.en) begin
      unique case (cfg.mode)
        MODE_LEVEL: begin trig = hit;           init_req = smp; end
        MODE_EDGE:  begin trig = hit && pend_q; init_req = pend_q; end
        MODE_PIPED: begin trig = retire;        init_req = (cnt_q != '0); end
        default:    begin trig = 1'b0;          init_req = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/xdr_ack_gen.sv
module xdr_ack_gen
  import xdr_pkg::*;
#(
  parameter int ACK_CW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              trig,
  input  logic [ACK_CW-1:0] load_val,
  output logic              ack
);
  logic [ACK_CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en)                cnt_d = '0;
    else if (trig)          cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ack = en && (cnt_q != '0);
endmodule

// File: rtl/xdr_dreq_ctrl.sv
module xdr_dreq_ctrl
  import xdr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int PIPE_DEPTH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              req_pin,
  input  logic              bus_valid,
  input  logic              bus_is_periph,
  input  logic              bus_is_read,
  output logic              init_req,
  output logic              ack_pin
);
  localparam int ACK_MAX = 1 << WID_W;
  localparam int ACK_CW  = $clog2(ACK_MAX + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  xdr_cfg_t          cfg;
  logic              smp, rise, hit, trig, direct;
  logic [ACK_CW-1:0] load_val;

  // reset asserts at once, releases two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign direct   = cfg.sync || (cfg.mode == MODE_PIPED);
  assign hit      = cfg.en && bus_valid && ({bus_is_periph, bus_is_read} == cfg.bsel);
  assign load_val = (cfg.mode == MODE_PIPED) ? ACK_CW'(1)
                                             : ACK_CW'(cfg.wid) + ACK_CW'(1);

  xdr_cfg_reg #(.DATA_W(DATA_W)) cfg_i (
    .clk(clk), .rst_n(rst_int_n), .we(cfg_we), .wdata(cfg_wdata),
    .cfg(cfg), .rdata(cfg_rdata)
  );

  xdr_req_front #(.STAGES(SYNC_STAGES)) front_i (
    .clk(clk), .rst_n(rst_int_n), .pin(req_pin), .direct(direct),
    .smp(smp), .rise(rise)
  );

  xdr_req_track #(.PIPE_DEPTH(PIPE_DEPTH)) track_i (
    .clk(clk), .rst_n(rst_int_n), .cfg(cfg), .smp(smp), .rise(rise),
    .hit(hit), .init_req(init_req), .trig(trig)
  );

  xdr_ack_gen #(.ACK_CW(ACK_CW)) ack_i (
    .clk(clk), .rst_n(rst_int_n), .en(cfg.en), .trig(trig),
    .load_val(load_val), .ack(ack_pin)
  );
endmodule

// File: rtl/xdr_dreq_ctrl_chk.sv
module xdr_dreq_ctrl_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              bus_valid,
  input logic              bus_is_periph,
  input logic              bus_is_read,
  input logic              init_req,
  input logic              ack_pin
);
  logic       en;
  logic [1:0] mode, bsel;
  logic       xfer_hit;

  assign en       = cfg_rdata[0];
  assign mode     = cfg_rdata[7:6];
  assign bsel     = cfg_rdata[5:4];
  assign xfer_hit = bus_valid && ({bus_is_periph, bus_is_read} == bsel);

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[DATA_W-1:8] == '0);

  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!init_req && !ack_pin));

  assert_idle_no_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 2'b00) |-> !init_req);

  assert_ack_needs_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_pin) |-> $past(xfer_hit));

  assert_pending_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 2'b10 && !cfg_we && init_req && !xfer_hit) |=> init_req);
endmodule

bind xdr_dreq_ctrl xdr_dreq_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
  .bus_valid(bus_valid), .bus_is_periph(bus_is_periph), .bus_is_read(bus_is_read),
  .init_req(init_req), .ack_pin(ack_pin)
);

// File: tb/xdr_dreq_ctrl_tb_top.sv
`timescale 1ns/1ps
module xdr_dreq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic        req_pin, bus_valid, bus_is_periph, bus_is_read;
  logic [31:0] cfg_rdata;
  logic        init_req, ack_pin;

  int checks = 0;
  int errors = 0;
  bit mdl_on = 1'b0;

  // behavioural reference state
  int pa, pb, sprev, pend, cnt, ackc;
  int r_en, r_mode, r_bsel, r_wid, r_sync;

  always #5 clk = ~clk;

  xdr_dreq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_pin(req_pin), .bus_valid(bus_valid),
    .bus_is_periph(bus_is_periph), .bus_is_read(bus_is_read),
    .init_req(init_req), .ack_pin(ack_pin)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic xfer(input logic periph, input logic rd);
    bus_valid = 1'b1; bus_is_periph = periph; bus_is_read = rd;
    @(negedge clk);
    bus_valid = 1'b0; bus_is_periph = 1'b0; bus_is_read = 1'b0;
  endtask

  function automatic int mdl_smp();
    return (r_mode == 3 || r_sync == 1) ? pa : pb;
  endfunction

  always @(posedge clk) begin
    if (!mdl_on) begin
      pa = 0; pb = 0; sprev = 0; pend = 0; cnt = 0; ackc = 0;
      r_en = 0; r_mode = 0; r_bsel = 0; r_wid = 0; r_sync = 0;
    end else begin
      int s, rise, m, trig, retire, inc;
      s = mdl_smp();
      rise = (s == 1 && sprev == 0) ? 1 : 0;
      m = (bus_valid && r_en == 1 &&
           ((bus_is_periph ? 2 : 0) + (bus_is_read ? 1 : 0)) == r_bsel) ? 1 : 0;
      trig = 0; retire = 0;
      if (r_en == 1) begin
        if (r_mode == 1) trig = m;
        if (r_mode == 2) trig = (m == 1 && pend == 1) ? 1 : 0;
        if (r_mode == 3) begin retire = (m == 1 && cnt > 0) ? 1 : 0; trig = retire; end
      end
      if (r_en == 1 && r_mode == 2) pend = (pend == 1) ? (m == 1 ? 0 : 1) : rise;
      else pend = 0;
      if (r_en == 1 && r_mode == 3) begin
        inc = (s == 1 && (cnt < 4 || retire == 1)) ? 1 : 0;
        cnt = cnt - retire + inc;
      end else cnt = 0;
      if (r_en == 0) ackc = 0;
      else if (trig == 1) ackc = (r_mode == 3) ? 1 : r_wid + 1;
      else if (ackc > 0) ackc = ackc - 1;
      sprev = s; pb = pa; pa = req_pin ? 1 : 0;
      if (cfg_we) begin
        r_en = int'(cfg_wdata[0]); r_sync = int'(cfg_wdata[1]);
        r_wid = int'(cfg_wdata[3:2]); r_bsel = int'(cfg_wdata[5:4]);
        r_mode = int'(cfg_wdata[7:6]);
      end
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (mdl_on) begin
      int ei, ea;
      string ti, ta;
      ei = 0;
      if (r_en == 1) begin
        if (r_mode == 1) ei = mdl_smp();
        if (r_mode == 2) ei = pend;
        if (r_mode == 3) ei = (cnt > 0) ? 1 : 0;
      end
      ea = (r_en == 1 && ackc > 0) ? 1 : 0;
      ti = (r_en == 0) ? "R2" : (r_mode == 0) ? "R3" : (r_mode == 1) ? "R5" :
           (r_mode == 2) ? "R8" : "R9";
      ta = (r_en == 0) ? "R2" : (r_mode == 0) ? "R3" : (r_mode == 3) ? "R9" : "R7";
      chk("R1 model readback", cfg_rdata,
          32'(r_mode * 64 + r_bsel * 16 + r_wid * 4 + r_sync * 2 + r_en));
      chk({ti, " model init_req"}, {31'b0, init_req}, 32'(ei));
      chk({ta, " model ack_pin"}, {31'b0, ack_pin}, 32'(ea));
    end
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int acks;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; req_pin = 1'b0;
    bus_valid = 1'b0; bus_is_periph = 1'b0; bus_is_read = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
    chk("R1 reset readback", cfg_rdata, 32'h0);
    chk("R2 reset init_req", {31'b0, init_req}, 32'h0);
    chk("R2 reset ack_pin", {31'b0, ack_pin}, 32'h0);
    mdl_on = 1'b1;

    // R1 reserved bits and field storage
    wr(32'hFFFF_FF00);
    chk("R1 reserved bits ignored", cfg_rdata, 32'h0);
    wr(32'h0000_005A);
    chk("R1 field readback", cfg_rdata, 32'h0000_005A);

    // R2 disabled: level mode, memory read select, enable clear
    req_pin = 1'b1; step(3);
    chk("R2 no request when disabled", {31'b0, init_req}, 32'h0);
    xfer(1'b0, 1'b1);
    chk("R2 no ack when disabled", {31'b0, ack_pin}, 32'h0);
    req_pin = 1'b0; step(3);

    // R3 idle mode enabled
    wr(32'h0000_0001);
    req_pin = 1'b1; step(3);
    chk("R3 idle no request", {31'b0, init_req}, 32'h0);
    xfer(1'b0, 1'b0);
    chk("R3 idle no ack", {31'b0, ack_pin}, 32'h0);
    req_pin = 1'b0; step(3);

    // R4 timing: level, sync then async
    wr(32'h0000_0043);
    step(2);
    req_pin = 1'b1; step(1);
    chk("R4 sync one-clock latency", {31'b0, init_req}, 32'h1);
    req_pin = 1'b0; step(3);
    wr(32'h0000_0041);
    step(2);
    req_pin = 1'b1; step(1);
    chk("R4 async not yet", {31'b0, init_req}, 32'h0);
    step(1);
    chk("R4 async two-clock latency", {31'b0, init_req}, 32'h1);
    req_pin = 1'b0; step(1);
    chk("R5 level follows pin low", {31'b0, init_req}, 32'h1);
    step(1);
    chk("R5 level drops", {31'b0, init_req}, 32'h0);
    step(2);

    // R6 / R7: level, peripheral write select, width 3 clocks, sync
    wr(32'h0000_006B);
    xfer(1'b0, 1'b0);
    chk("R6 memory write does not match", {31'b0, ack_pin}, 32'h0);
    step(1);
    chk("R6 still no ack", {31'b0, ack_pin}, 32'h0);
    xfer(1'b1, 1'b0);
    chk("R6 peripheral write matches", {31'b0, ack_pin}, 32'h1);
    step(1);
    chk("R7 ack clock 2", {31'b0, ack_pin}, 32'h1);
    step(1);
    chk("R7 ack clock 3", {31'b0, ack_pin}, 32'h1);
    step(1);
    chk("R7 ack ends after 3", {31'b0, ack_pin}, 32'h0);
    step(2);

    // R10 restart: width 4 clocks
    wr(32'h0000_006F);
    xfer(1'b1, 1'b0);
    step(1);
    xfer(1'b1, 1'b0);
    step(3);
    chk("R10 pulse restarted", {31'b0, ack_pin}, 32'h1);
    step(1);
    chk("R10 restarted pulse ends", {31'b0, ack_pin}, 32'h0);
    step(2);

    // R8 edge mode, memory write select, width 1, sync
    wr(32'h0000_0083);
    step(2);
    req_pin = 1'b1; step(1);
    chk("R8 edge not yet pending", {31'b0, init_req}, 32'h0);
    step(1);
    chk("R8 edge sets pending", {31'b0, init_req}, 32'h1);
    req_pin = 1'b0; step(2);
    req_pin = 1'b1; step(2);
    xfer(1'b0, 1'b0);
    chk("R8 ack on match", {31'b0, ack_pin}, 32'h1);
    chk("R8 pending cleared", {31'b0, init_req}, 32'h0);
    step(3);
    chk("R8 second edge not queued", {31'b0, init_req}, 32'h0);
    chk("R8 no extra ack", {31'b0, ack_pin}, 32'h0);
    req_pin = 1'b0; step(2);

    // R9 piped, width field 4, timing bit async (both ignored)
    wr(32'h0000_00CD);
    step(2);
    req_pin = 1'b1; step(1);
    chk("R9 count empty after one clock", {31'b0, init_req}, 32'h0);
    step(1);
    chk("R4 piped uses one-flop path", {31'b0, init_req}, 32'h1);
    step(4);
    req_pin = 1'b0; step(3);
    acks = 0;
    for (int i = 0; i < 5; i++) begin
      xfer(1'b0, 1'b0);
      if (ack_pin) acks++;
      step(1);
      chk("R9 ack lasts one clock", {31'b0, ack_pin}, 32'h0);
    end
    chk("R9 depth saturates at 4", 32'(acks), 32'd4);
    chk("R9 store empty", {31'b0, init_req}, 32'h0);

    wr(32'h0000_0000);
    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule